// File: doc/BRIEF.md
# General-Purpose Input Interrupt Collector with Dual-Mode Interrupt Pin

This block turns transitions on eight general-purpose input pins into sticky interrupt flags and merges them with a group of interrupt requests raised elsewhere in the chip. It then drives a single interrupt pin towards an external processor. Each pin has its own enable bit and its own edge-select bit. Software clears a flag by writing a 1 to that flag's position.

The interrupt pin works in one of two modes. In level mode it behaves as an open-drain, active-low line. The data output is held low, and the output enable is on for as long as any enabled request is pending. In edge mode the pin is always driven. It rests at an inactive level and gives one pulse of programmable length at a selectable polarity. A pulse starts when a new request appears while no pulse is running.

Software can also move the pin interrupts off the main line onto a separate secondary request output. External requests always stay on the main line. All register writes arrive through a plain single-cycle write port.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, all flags, enables and edge-select bits are 0 and the control byte is 8'h10. `int_oe_o`, `int_o` and `sec_irq_o` are all 0.
- R2: Each pin passes through a two-flop synchroniser. Edge-select bit 0 flags a falling edge and bit 1 flags a rising edge. A pin change made between two clock edges shows up in its flag right after the third following rising clock edge. The opposite edge sets nothing.
- R3: A write with `wr_sel_i` = 0 clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. If an edge and a clear hit the same flag in the same cycle, the flag stays set.
- R4: In level mode (control bit 1 = 0), `int_o` is always 0. `int_oe_o` is 1 exactly when the global enable is set and at least one request is pending. A request is either an external request or a flag whose enable bit is set. A flag whose enable bit is clear is still recorded, and it becomes pending as soon as its enable bit is set.
- R5: In edge mode (control bit 1 = 1), `int_oe_o` is 1 at all times. `int_o` rests at the inverse of control bit 2 and pulses to control bit 2 for 128 << code cycles, where code is control bits 4:3. The pulse starts one clock after a new request appears.
- R6: A request that appears while a pulse is running does not lengthen or restart the pulse. A request that appears after the pulse has ended starts a new pulse.
- R7: When control bits 6:5 are 2'b10 and control bit 7 is 1, pin requests leave the main line. `sec_irq_o` is then 1 exactly when the global enable is set and an enabled flag is pending. With any other setting, `sec_irq_o` is 0.
- R8: With the global enable (control bit 0) clear, level mode never enables the output and edge mode never starts a pulse.
- R9: The write port decodes `wr_sel_i` as follows: 0 for the flags (write 1 to clear), 1 for the enables, 2 for the edge selects and 3 for the control byte. A write takes effect on the clock edge at which `wr_en_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| gpin_i | input | NUM_PINS | Raw general-purpose input pins |
| ext_irq_i | input | NUM_EXT | Active-high interrupt requests from other units |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| int_o | output | 1 | Interrupt pin data |
| int_oe_o | output | 1 | Interrupt pin output enable |
| sec_irq_o | output | 1 | Secondary interrupt request carrying the pin interrupts |

## Verification
Level mode is exercised with falling edges and rising edges on separate pins, with a disabled pin whose flag is enabled later, and with external requests. Together these show apart edge-select decoding, enable gating and flag persistence. Edge mode is tried with three pulse-width codes and both polarities, which catches wrong shift amounts and an inverted rest level. A second request arrives in the middle of a pulse to tell a one-shot generator apart from a retriggering one, and an edge is timed to land in the same cycle as a clear to confirm that the set wins. A behavioural reference model runs alongside and checks all three outputs on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_POL  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // control byte, MSB first
  typedef struct packed {
    logic       sep;     // bit 7: move pin requests to secondary output
    logic [1:0] gpx;     // bits 6:5: auxiliary output select
    logic [1:0] pw;      // bits 4:3: pulse width code
    logic       ppol;    // bit 2: active pulse level in edge mode
    logic       edge_m;  // bit 1: 1 = edge mode, 0 = level mode
    logic       ie;      // bit 0: global interrupt enable
  } ctrl_t;

  localparam logic [REG_W-1:0] CTRL_RST     = 8'h10;
  localparam logic [1:0]       GPX_GPIN_IRQ = 2'b10;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] cur_o,
  output logic [NUM_PINS-1:0] prev_o
);

  localparam int STAGES = 3;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], pin_i[g]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= pipe_d;
    end

    assign cur_o[g]  = pipe_q[1];
    assign prev_o[g] = pipe_q[2];
  end

endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] cur_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic                wr_flag_i,
  input  logic                wr_en_i,
  input  logic                wr_pol_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  output logic [NUM_PINS-1:0] flag_o,
  output logic [NUM_PINS-1:0] en_o
);

  logic [NUM_PINS-1:0] flag_q, flag_d;
  logic [NUM_PINS-1:0] en_q, en_d;
  logic [NUM_PINS-1:0] pol_q, pol_d;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] clr_mask;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_edge
    always_comb begin
      if (pol_q[g]) edge_hit[g] = cur_i[g] & ~prev_i[g];
      else          edge_hit[g] = ~cur_i[g] & prev_i[g];
    end
  end

  always_comb begin
    clr_mask = wr_flag_i ? wr_data_i : '0;
    flag_d   = (flag_q & ~clr_mask) | edge_hit;
    en_d     = wr_en_i  ? wr_data_i : en_q;
    pol_d    = wr_pol_i ? wr_data_i : pol_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_en_i)  en_q  <= en_d;
      if (wr_pol_i) pol_q <= pol_d;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;

  // R2: a detected edge always leaves its flag set
  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

  // R3: a clear without a coinciding edge empties the flag
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_mask & ~edge_hit) != '0) |=> ((flag_q & $past(clr_mask & ~edge_hit)) == '0));

endmodule

// File: rtl/int_pulse_gen.sv
module int_pulse_gen #(
  parameter int SRC_W   = 12,
  parameter int PW_BASE = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] pend_i,
  input  logic             arm_i,
  input  logic [1:0]       pw_code_i,
  output logic             active_o
);

  localparam int CW = $clog2(PW_BASE * 8 + 1);

  logic [SRC_W-1:0] pend_q;
  logic [SRC_W-1:0] new_bits;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    width;
  logic             trig;

  always_comb begin
    new_bits = pend_i & ~pend_q;
    width    = CW'(PW_BASE) << pw_code_i;
    trig     = arm_i && (new_bits != '0) && (cnt_q == '0);
    if (trig)              cnt_d = width;
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_i;
      cnt_q  <= cnt_d;
    end
  end

  assign active_o = (cnt_q != '0);

  // R6: a pulse only begins after a new request was seen while armed
  p_start_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(arm_i && ((pend_i & ~pend_q) != '0)));

  // R8: no pulse begins while disarmed
  p_disarmed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !active_o) |=> !active_o);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_EXT  = 4,
  parameter int PW_BASE  = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] gpin_i,
  input  logic [NUM_EXT-1:0]  ext_irq_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic                int_o,
  output logic                int_oe_o,
  output logic                sec_irq_o
);

  localparam int SRC_W = NUM_PINS + NUM_EXT;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // write decode
  logic wr_flag, wr_en, wr_pol, wr_ctrl;

  always_comb begin
    wr_flag = wr_en_i && (wr_sel_i == SEL_FLAG);
    wr_en   = wr_en_i && (wr_sel_i == SEL_EN);
    wr_pol  = wr_en_i && (wr_sel_i == SEL_POL);
    wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  end

  // control register
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wr_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= ctrl_t'(CTRL_RST);
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  // pin capture and flags
  logic [NUM_PINS-1:0] cur, prev, flag, en;

  gpio_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pin_i  (gpin_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  gpio_flag_bank #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cur_i     (cur),
    .prev_i    (prev),
    .wr_flag_i (wr_flag),
    .wr_en_i   (wr_en),
    .wr_pol_i  (wr_pol),
    .wr_data_i (wr_data_i[NUM_PINS-1:0]),
    .flag_o    (flag),
    .en_o      (en)
  );

  // request routing
  logic                gpin_act;
  logic                sep_route;
  logic [NUM_PINS-1:0] gpin_main;
  logic [SRC_W-1:0]    pend;

  always_comb begin
    sep_route = ctrl_q.sep && (ctrl_q.gpx == GPX_GPIN_IRQ);
    gpin_act  = |(flag & en);
    gpin_main = sep_route ? '0 : (flag & en);
    pend      = {ext_irq_i, gpin_main};
  end

  // pulse generator
  logic pulse_act;

  int_pulse_gen #(.SRC_W(SRC_W), .PW_BASE(PW_BASE)) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .pend_i    (pend),
    .arm_i     (ctrl_q.ie && ctrl_q.edge_m),
    .pw_code_i (ctrl_q.pw),
    .active_o  (pulse_act)
  );

  // pin drive
  always_comb begin
    if (ctrl_q.edge_m) begin
      int_oe_o = 1'b1;
      int_o    = pulse_act ? ctrl_q.ppol : ~ctrl_q.ppol;
    end else begin
      int_oe_o = ctrl_q.ie && (pend != '0);
      int_o    = 1'b0;
    end
    sec_irq_o = ctrl_q.ie && sep_route && gpin_act;
  end

  // R4: open-drain line never drives high
  p_level_low_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctrl_q.edge_m |-> !int_o);

  // R5: push-pull line always enabled
  p_edge_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ctrl_q.edge_m |-> int_oe_o);

  // R7: secondary output silent unless routed
  p_sec_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sep_route |-> !sec_irq_o);

  // R8: level mode gated by global enable
  p_ie_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ctrl_q.ie && !ctrl_q.edge_m) |-> !int_oe_o);

endmodule

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
  localparam int N   = 8;
  localparam int E   = 4;
  localparam int PWB = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0] pin = '0;
  logic [E-1:0] ext = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [7:0]   wr_data = '0;
  wire          int_o, int_oe, sec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  gpio_irq_unit #(.NUM_PINS(N), .NUM_EXT(E), .PW_BASE(PWB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .gpin_i(pin), .ext_irq_i(ext),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .int_o(int_o), .int_oe_o(int_oe), .sec_irq_o(sec)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [N-1:0]   m_s1, m_s2, m_s3, m_flag, m_en, m_pol;
  logic [7:0]     m_ctrl;
  logic [N+E-1:0] m_prev;
  int             m_cnt, m_rc;

  function automatic logic [N+E-1:0] m_pend();
    bit routed;
    routed = m_ctrl[7] && (m_ctrl[6:5] == 2'b10);
    return {ext, routed ? N'(0) : (m_flag & m_en)};
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [N-1:0]   ed;
    logic [N+E-1:0] p;
    bit             trig;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_flag = '0; m_en = '0; m_pol = '0;
      m_ctrl = 8'h10; m_prev = '0; m_cnt = 0; m_rc = 0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      for (int i = 0; i < N; i++)
        ed[i] = m_pol[i] ? (m_s2[i] & ~m_s3[i]) : (~m_s2[i] & m_s3[i]);
      p    = m_pend();
      trig = m_ctrl[0] && m_ctrl[1] && ((p & ~m_prev) != '0) && (m_cnt == 0);
      if (trig)           m_cnt = PWB << m_ctrl[4:3];
      else if (m_cnt > 0) m_cnt--;
      m_prev = p;
      if (wr_en && wr_sel == 2'd0) m_flag = m_flag & ~wr_data[N-1:0];
      m_flag = m_flag | ed;
      if (wr_en && wr_sel == 2'd1) m_en   = wr_data[N-1:0];
      if (wr_en && wr_sel == 2'd2) m_pol  = wr_data[N-1:0];
      if (wr_en && wr_sel == 2'd3) m_ctrl = wr_data;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  always @(negedge clk) begin : compare
    bit e_oe, e_int, e_sec;
    logic [N+E-1:0] p;
    if (rst_n && !done) begin
      p = m_pend();
      if (m_ctrl[1]) begin
        e_oe  = 1'b1;
        e_int = (m_cnt > 0) ? m_ctrl[2] : ~m_ctrl[2];
      end else begin
        e_oe  = m_ctrl[0] && (p != '0);
        e_int = 1'b0;
      end
      e_sec = m_ctrl[0] && m_ctrl[7] && (m_ctrl[6:5] == 2'b10) && ((m_flag & m_en) != '0);
      chk(int_oe === e_oe, m_ctrl[1] ? "R5" : "R4", "model int_oe", int'(int_oe), int'(e_oe));
      chk(int_o === e_int, m_ctrl[1] ? "R5" : "R4", "model int_o", int'(int_o), int'(e_int));
      chk(sec === e_sec, "R7", "model sec_irq", int'(sec), int'(e_sec));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (int_o === lvl) n++;
      else if (n > 0) break;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin : main
    int n;
    ticks(3);
    rst_n = 1'b1;
    #2;
    look();
    // R1: reset state
    chk(int_oe == 1'b0 && int_o == 1'b0 && sec == 1'b0, "R1", "outputs after reset",
        {int_oe, int_o, sec}, 0);
    ticks(4);

    // R2, R9: falling edge detected with three-edge latency
    pin[0] = 1'b1;
    ticks(5);
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h11);
    look(); chk(int_oe == 1'b0, "R2", "rising edge under falling select", int_oe, 0);
    tick();
    pin[0] = 1'b0;
    tick(); tick();
    look(); chk(int_oe == 1'b0, "R2", "flag not yet set after two edges", int_oe, 0);
    tick();
    look(); chk(int_oe == 1'b1, "R2", "flag set after third edge", int_oe, 1);
    tick();

    // R3: write 0 ignored, write 1 clears
    wr(2'd0, 8'h00);
    look(); chk(int_oe == 1'b1, "R3", "write zero keeps flag", int_oe, 1);
    tick();
    wr(2'd0, 8'h01);
    look(); chk(int_oe == 1'b0, "R3", "write one clears flag", int_oe, 0);
    tick();

    // R4: disabled flag recorded but not pending
    pin[1] = 1'b1; ticks(4); pin[1] = 1'b0; ticks(5);
    look(); chk(int_oe == 1'b0, "R4", "disabled flag not pending", int_oe, 0);
    tick();
    wr(2'd1, 8'h03);
    look(); chk(int_oe == 1'b1, "R4", "enabling held flag", int_oe, 1);
    tick();
    wr(2'd0, 8'h02);

    // R2: rising-edge select
    wr(2'd2, 8'h04);
    wr(2'd1, 8'h04);
    pin[2] = 1'b1; ticks(4);
    look(); chk(int_oe == 1'b1, "R2", "rising edge flagged", int_oe, 1);
    tick();
    wr(2'd0, 8'h04);
    pin[2] = 1'b0; ticks(4);
    look(); chk(int_oe == 1'b0, "R2", "falling edge ignored under rising select", int_oe, 0);
    tick();

    // R4, R8: external request and global enable
    ext[0] = 1'b1;
    look(); chk(int_oe == 1'b1, "R4", "external request", int_oe, 1);
    tick();
    wr(2'd3, 8'h10);
    look(); chk(int_oe == 1'b0, "R8", "level mode with enable clear", int_oe, 0);
    tick();
    ext = '0;
    wr(2'd3, 8'h11);

    // R3: set and clear in the same cycle
    wr(2'd1, 8'h08);
    pin[3] = 1'b1; ticks(4);
    pin[3] = 1'b0;
    tick(); tick();
    wr(2'd0, 8'h08);
    look(); chk(int_oe == 1'b1, "R3", "set wins over same-cycle clear", int_oe, 1);
    tick();
    wr(2'd0, 8'h08);
    look(); chk(int_oe == 1'b0, "R3", "later clear", int_oe, 0);
    tick();

    // R7: routing to the secondary output
    wr(2'd3, 8'hC1);
    pin[3] = 1'b1; ticks(4); pin[3] = 1'b0; ticks(5);
    look();
    chk(int_oe == 1'b0, "R7", "routed pin leaves main line", int_oe, 0);
    chk(sec == 1'b1, "R7", "routed pin on secondary", sec, 1);
    tick();
    wr(2'd3, 8'hA1);
    look();
    chk(sec == 1'b0, "R7", "other select keeps secondary low", sec, 0);
    chk(int_oe == 1'b1, "R7", "other select returns to main line", int_oe, 1);
    tick();
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);

    // R5: pulse widths and polarity
    wr(2'd3, 8'h07);
    look();
    chk(int_oe == 1'b1 && int_o == 1'b0, "R5", "edge mode rest level high-active",
        {int_oe, int_o}, 2);
    tick();
    ext[0] = 1'b1;
    measure(1'b1, n); chk(n == 128, "R5", "pulse width code 00", n, 128);
    tick(); ext = '0; tick();
    wr(2'd3, 8'h0B);
    look(); chk(int_o == 1'b1, "R5", "rest level low-active", int_o, 1);
    tick();
    ext[1] = 1'b1;
    measure(1'b0, n); chk(n == 256, "R5", "pulse width code 01", n, 256);
    tick(); ext = '0; tick();
    wr(2'd3, 8'h17);
    ext[2] = 1'b1;
    measure(1'b1, n); chk(n == 512, "R5", "pulse width code 10", n, 512);
    tick(); ext = '0; tick();

    // R6: no retrigger during a pulse, new pulse afterwards
    wr(2'd3, 8'h07);
    ext[0] = 1'b1;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (int_o === 1'b1) n++;
      else if (n > 0) break;
      if (n == 10) ext[1] = 1'b1;
    end
    chk(n == 128, "R6", "mid-pulse request ignored", n, 128);
    tick();
    ext[2] = 1'b1;
    measure(1'b1, n); chk(n == 128, "R6", "new pulse after end", n, 128);
    tick(); ext = '0; tick();

    // R8: edge mode with enable clear
    wr(2'd3, 8'h06);
    ext[3] = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (int_o === 1'b1) n++;
    end
    chk(n == 0, "R8", "no pulse while disabled", n, 0);
    tick(); ext = '0; ticks(3);

    finish_run();
  end
endmodule